// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a memory-mapped watchdog for a slow functional tick. A 32-bit up-counter advances on each `tick` pulse, either directly or through a power-of-two prescaler. Software keeps the system alive by writing a fresh value to the trigger register, which reloads the counter from the load register. If the counter wraps past all ones while the watchdog is running, the block pulses `reset_req` for one clock and restarts from the load value.

The watchdog can only be started or stopped by an ordered pair of key words written to the key register. Writes to the control, load, trigger and key registers are posted: each one waits a fixed number of clocks (`POST_CYC`) before it takes effect, and a pending-status register shows which of them is still in flight. The register bus has no back-pressure. A write is accepted in the cycle `bus_wr` is high. A read returns `bus_rdata` combinationally from `bus_addr` in the same cycle. Software must poll the pending bit of a register before writing to it again.

Top module: `keyseq_wdog`

## Requirements
- R1: After reset the watchdog is running, the counter (offset 0x28) and load register (0x2C) read 0xFFFF8000, the trigger register (0x30) reads 0, the pending register (0x34) reads 0 and `reset_req` is low.
- R2: A write to control (0x24), load (0x2C), trigger (0x30) or key (0x48) sets pending bit 0, 2, 3 or 4 respectively of register 0x34. The bit stays set for exactly `POST_CYC` clocks, and the written value takes effect in the cycle the bit clears.
- R3: A write to a posted register while its own pending bit is set is ignored; the earlier value is the one that takes effect.
- R4: Key word 0xBBBB followed by 0x4444 starts the watchdog. Key word 0xAAAA followed by 0x5555 stops it.
- R5: If a key pair is broken, the enable state does not change. A pair is broken when the second applied key word is not the partner of the first, or when another key word comes between the two.
- R6: A trigger write whose value differs from the trigger register reloads the counter from the load register. A trigger write of the same value leaves the counter unchanged.
- R7: While running with the prescaler off, the counter increases by one for each `tick`. While stopped, it holds its value.
- R8: Control bit 5 enables the prescaler and control bits 4:2 hold an exponent P. With the prescaler on, the counter advances once every 2^P ticks, counted from the last control write or reload.
- R9: When a running counter at 0xFFFFFFFF advances, `reset_req` is high for exactly one clock and the counter reloads from the load register.
- R10: The low byte of the revision register (0x00) reads `REV_CODE`. Bit 0 of the system configuration register (0x10) is read/write and takes effect at once, with its other bits reading 0. The status register (0x14) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, accepted in the same cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 1 | One-clock pulse of the slow functional tick |
| reset_req | output | 1 | One-clock reset request on timeout |

## Verification
The bench builds the block with `POST_CYC` = 3 and keeps the default 3-bit prescale exponent. With this short posting delay, the bench can count the full pending window clock by clock, and it can place a second write inside that window to show the write is dropped. A load value just below all ones makes a wrap occur after a few ticks, so the reset pulse and the reload can both be observed. An exponent of 2 shows the prescaler gating within a dozen ticks.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam logic [7:0] OFS_REV  = 8'h00;
  localparam logic [7:0] OFS_SYSC = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_CTRL = 8'h24;
  localparam logic [7:0] OFS_CNT  = 8'h28;
  localparam logic [7:0] OFS_LOAD = 8'h2C;
  localparam logic [7:0] OFS_TRIG = 8'h30;
  localparam logic [7:0] OFS_PEND = 8'h34;
  localparam logic [7:0] OFS_KEY  = 8'h48;

  localparam logic [31:0] KEY_ON_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ON_B  = 32'h0000_4444;
  localparam logic [31:0] KEY_OFF_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_OFF_B = 32'h0000_5555;

  localparam int NSLOT     = 4;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_LOAD = 1;
  localparam int SLOT_TRIG = 2;
  localparam int SLOT_KEY  = 3;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_ON_HALF = 2'd1,
    KS_OFF_HALF = 2'd2
  } key_st_e;

  function automatic logic [7:0] slot_ofs(input int s);
    case (s)
      SLOT_CTRL: slot_ofs = OFS_CTRL;
      SLOT_LOAD: slot_ofs = OFS_LOAD;
      SLOT_TRIG: slot_ofs = OFS_TRIG;
      default:   slot_ofs = OFS_KEY;
    endcase
  endfunction

  function automatic int pend_pos(input int s);
    case (s)
      SLOT_CTRL: pend_pos = 0;
      SLOT_LOAD: pend_pos = 2;
      SLOT_TRIG: pend_pos = 3;
      default:   pend_pos = 4;
    endcase
  endfunction

endpackage

// File: rtl/wdk_post.sv
// One posted-write slot: captures a write, holds it for DELAY clocks,
// then fires for one cycle so the owner can apply it.
module wdk_post #(
  parameter int W     = 32,
  parameter int DELAY = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic         fire,
  output logic [W-1:0] data
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  data_q;

  assign busy = (cnt_q != '0);
  assign fire = (cnt_q == CW'(1));
  assign data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (wr_req && !busy) begin
      data_q <= wdata;
      cnt_q  <= CW'(DELAY);
    end else if (busy) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_req) |=> $stable(data_q)); // R3

  AST_FIRE_ENDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy); // R2

endmodule

// File: rtl/wdk_keyseq.sv
// Two-word key sequencer for starting and stopping the watchdog.
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        apply_i,
  input  logic [31:0] word_i,
  output logic        en_o
);
  key_st_e st_q;
  logic    en_q;

  assign en_o = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_IDLE;
      en_q <= 1'b1;
    end else if (apply_i) begin
      if (st_q == KS_ON_HALF && word_i == KEY_ON_B) begin
        en_q <= 1'b1;
        st_q <= KS_IDLE;
      end else if (st_q == KS_OFF_HALF && word_i == KEY_OFF_B) begin
        en_q <= 1'b0;
        st_q <= KS_IDLE;
      end else if (word_i == KEY_ON_A) begin
        st_q <= KS_ON_HALF;
      end else if (word_i == KEY_OFF_A) begin
        st_q <= KS_OFF_HALF;
      end else begin
        st_q <= KS_IDLE;
      end
    end
  end

  AST_EN_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(en_q)); // R5

  AST_START_NEEDS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(st_q) == KS_ON_HALF); // R4

endmodule

// File: rtl/wdk_count.sv
// Prescaled up-counter with reload and wrap detection.
module wdk_count #(
  parameter int          CW      = 32,
  parameter int          PW      = 3,
  parameter logic [31:0] RST_VAL = 32'hFFFF_8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          pre_en_i,
  input  logic [PW-1:0] ptv_i,
  input  logic          pre_clr_i,
  input  logic          reload_i,
  input  logic [CW-1:0] load_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam int DW = 1 << PW;

  logic [DW-1:0] pre_q;
  logic [DW-1:0] pre_lim;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          pre_wrap;
  logic          adv;

  assign pre_lim  = ({{(DW-1){1'b0}}, 1'b1} << ptv_i) - {{(DW-1){1'b0}}, 1'b1};
  assign pre_wrap = (pre_q == pre_lim);
  assign adv      = en_i && tick_i && (!pre_en_i || pre_wrap);
  assign cnt_o    = cnt_q;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_clr_i || !pre_en_i) begin
      pre_q <= '0;
    end else if (en_i && tick_i) begin
      pre_q <= pre_wrap ? '0 : pre_q + {{(DW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL[CW-1:0];
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (reload_i) begin
        cnt_q <= load_i;
      end else if (adv) begin
        if (&cnt_q) begin
          cnt_q <= load_i;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
      end
    end
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !reload_i) |=> $stable(cnt_q)); // R7

  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q == $past(load_i))); // R9

  AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(&load_i)) |=> !ovf_q); // R9

endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
  import wdk_pkg::*;
#(
  parameter int          POST_CYC = 6,
  parameter int          PRE_W    = 3,
  parameter logic [7:0]  REV_CODE = 8'h31,
  parameter logic [31:0] RST_LOAD = 32'hFFFF_8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick,
  output logic        reset_req
);
  localparam int PRE_EN_BIT = 2 + PRE_W;

  logic [NSLOT-1:0] slot_wr;
  logic [NSLOT-1:0] slot_busy;
  logic [NSLOT-1:0] slot_fire;
  logic [31:0]      slot_data [NSLOT];

  logic [31:0] ctrl_q, load_q, trig_q, key_q;
  logic        sysc_q;
  logic [31:0] pend_vec;
  logic [31:0] cnt;
  logic        wd_en;
  logic        reload;
  logic        pre_clr;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_wr[g] = bus_wr && (bus_addr == slot_ofs(g));
    wdk_post #(.W(32), .DELAY(POST_CYC)) u_post (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_req (slot_wr[g]),
      .wdata  (bus_wdata),
      .busy   (slot_busy[g]),
      .fire   (slot_fire[g]),
      .data   (slot_data[g])
    );
  end

  assign reload  = slot_fire[SLOT_TRIG] && (slot_data[SLOT_TRIG] != trig_q);
  assign pre_clr = reload || slot_fire[SLOT_CTRL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= RST_LOAD;
      trig_q <= '0;
      key_q  <= '0;
      sysc_q <= 1'b0;
    end else begin
      if (slot_fire[SLOT_CTRL]) ctrl_q <= slot_data[SLOT_CTRL];
      if (slot_fire[SLOT_LOAD]) load_q <= slot_data[SLOT_LOAD];
      if (slot_fire[SLOT_TRIG]) trig_q <= slot_data[SLOT_TRIG];
      if (slot_fire[SLOT_KEY])  key_q  <= slot_data[SLOT_KEY];
      if (bus_wr && bus_addr == OFS_SYSC) sysc_q <= bus_wdata[0];
    end
  end

  wdk_keyseq u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .apply_i (slot_fire[SLOT_KEY]),
    .word_i  (slot_data[SLOT_KEY]),
    .en_o    (wd_en)
  );

  wdk_count #(.CW(32), .PW(PRE_W), .RST_VAL(RST_LOAD)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .en_i      (wd_en),
    .pre_en_i  (ctrl_q[PRE_EN_BIT]),
    .ptv_i     (ctrl_q[PRE_EN_BIT-1:2]),
    .pre_clr_i (pre_clr),
    .reload_i  (reload),
    .load_i    (load_q),
    .cnt_o     (cnt),
    .ovf_o     (reset_req)
  );

  always_comb begin
    pend_vec = '0;
    for (int s = 0; s < NSLOT; s++) pend_vec[pend_pos(s)] = slot_busy[s];
  end

  always_comb begin
    case (bus_addr)
      OFS_REV:  bus_rdata = {24'd0, REV_CODE};
      OFS_SYSC: bus_rdata = {31'd0, sysc_q};
      OFS_STAT: bus_rdata = '0;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_CNT:  bus_rdata = cnt;
      OFS_LOAD: bus_rdata = load_q;
      OFS_TRIG: bus_rdata = trig_q;
      OFS_PEND: bus_rdata = pend_vec;
      OFS_KEY:  bus_rdata = key_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_NEW_TRIG_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(load_q))); // R6

  AST_SAME_TRIG_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire[SLOT_TRIG] && slot_data[SLOT_TRIG] == trig_q && !wd_en) |=> $stable(cnt)); // R6

  AST_PEND_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr[SLOT_LOAD] && !slot_busy[SLOT_LOAD]) |=> pend_vec[2]); // R2

endmodule

// File: tb/keyseq_wdog_test.sv
`timescale 1ns/1ps
module keyseq_wdog_test;
  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  int req_seen = 0;

  always #2.5 clk = ~clk;

  keyseq_wdog #(.POST_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .reset_req(reset_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_wait(input logic [7:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (D) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] expect_add(input logic [31:0] base, input int n);
    return base + 32'(n);
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (reset_req) req_seen++;
      @(negedge clk);
      if (reset_req) begin
        errors++; checks++;
        $display("FAIL R9: actual reset_req 1 expected 0 one clock after the pulse");
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10 reset values
    rd(8'h28, v); chk("R1 counter", v, 32'hFFFF_8000);
    rd(8'h2C, v); chk("R1 load", v, 32'hFFFF_8000);
    rd(8'h30, v); chk("R1 trigger", v, 32'h0);
    rd(8'h34, v); chk("R1 pending", v, 32'h0);
    chk("R1 reset_req", {31'd0, reset_req}, 32'h0);
    rd(8'h00, v); chk("R10 revision", v & 32'hFF, 32'h31);

    // R7 running from reset
    ticks(5);
    rd(8'h28, v); chk("R7 count after 5 ticks", v, 32'hFFFF_8005);

    // R2 pending window for load
    wr(8'h2C, 32'h0000_1000);
    rd(8'h34, v); chk("R2 pending set", v, 32'h4);
    repeat (D-1) @(negedge clk);
    rd(8'h34, v); chk("R2 pending held", v, 32'h4);
    rd(8'h2C, v); chk("R2 load not yet applied", v, 32'hFFFF_8000);
    @(negedge clk);
    rd(8'h34, v); chk("R2 pending clear", v, 32'h0);
    rd(8'h2C, v); chk("R2 load applied", v, 32'h0000_1000);
    wr(8'h48, 32'h0000_1234);
    rd(8'h34, v); chk("R2 key pending bit4", v, 32'h10);
    repeat (D) @(negedge clk);
    wr(8'h24, 32'h0);
    rd(8'h34, v); chk("R2 control pending bit0", v, 32'h1);
    repeat (D) @(negedge clk);

    // R3 write during pending is dropped
    wr(8'h2C, 32'h0000_2000);
    wr(8'h2C, 32'h0000_3000);
    repeat (D) @(negedge clk);
    rd(8'h2C, v); chk("R3 second load dropped", v, 32'h0000_2000);

    // R6 trigger reloads on new value only
    wr_wait(8'h30, 32'h1);
    rd(8'h28, v); chk("R6 new trigger reloads", v, 32'h0000_2000);
    rd(8'h34, v); chk("R2 trigger pending cleared", v, 32'h0);
    ticks(3);
    wr_wait(8'h30, 32'h1);
    rd(8'h28, v); chk("R6 same trigger no reload", v, 32'h0000_2003);

    // R4 stop
    wr_wait(8'h48, 32'hAAAA);
    wr_wait(8'h48, 32'h5555);
    ticks(4);
    rd(8'h28, v); chk("R4 stopped holds (R7)", v, 32'h0000_2003);

    // R5 broken sequences
    wr_wait(8'h48, 32'hBBBB);
    wr_wait(8'h48, 32'h1234);
    wr_wait(8'h48, 32'h4444);
    ticks(2);
    rd(8'h28, v); chk("R5 foreign word between", v, 32'h0000_2003);
    wr_wait(8'h48, 32'hBBBB);
    wr_wait(8'h48, 32'hAAAA);
    wr_wait(8'h48, 32'h4444);
    ticks(2);
    rd(8'h28, v); chk("R5 wrong partner", v, 32'h0000_2003);

    // R4 start
    wr_wait(8'h48, 32'hBBBB);
    wr_wait(8'h48, 32'h4444);
    ticks(2);
    rd(8'h28, v); chk("R4 started counts", v, 32'h0000_2005);

    // R8 prescaler 2^2
    wr_wait(8'h24, 32'h28);
    wr_wait(8'h30, 32'h2);
    ticks(3);
    rd(8'h28, v); chk("R8 three ticks no step", v, 32'h0000_2000);
    ticks(1);
    rd(8'h28, v); chk("R8 fourth tick steps", v, 32'h0000_2001);
    ticks(8);
    rd(8'h28, v); chk("R8 eight more ticks", v, 32'h0000_2003);
    wr_wait(8'h24, 32'h0);

    // R9 wrap
    wr_wait(8'h2C, 32'hFFFF_FFFD);
    wr_wait(8'h30, 32'h3);
    req_seen = 0;
    ticks(2);
    chk("R9 no request before wrap", 32'(req_seen), 32'd0);
    rd(8'h28, v); chk("R9 at all ones", v, 32'hFFFF_FFFF);
    ticks(1);
    chk("R9 one request", 32'(req_seen), 32'd1);
    rd(8'h28, v); chk("R9 reloaded after wrap", v, 32'hFFFF_FFFD);

    // R10 config and status
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R10 sysconfig bit0", v, 32'h1);
    rd(8'h14, v); chk("R10 status", v, 32'h0);

    // R7 / R6 random loads and tick counts
    for (int i = 0; i < 16; i++) begin
      int k;
      base = $urandom & 32'h7FFF_FFFF;
      k = $urandom_range(0, 12);
      wr_wait(8'h2C, base);
      wr_wait(8'h30, 32'(100 + i));
      rd(8'h28, v); chk("R6 random reload", v, base);
      ticks(k);
      rd(8'h28, v); chk("R7 random ticks", v, expect_add(base, k));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule